// File: doc/BRIEF.md
# Interrupt Controller Command and Acknowledge Unit

This unit is the register front end and sequencing logic of one eight-line interrupt controller. Software talks to it through two byte-wide addresses. One is the command port and the other is the data port. Writes to these ports walk through a multi-word initialisation sequence, program the mask, and issue end-of-interrupt, rotation and read-control commands. Reads return the pending, in-service or mask register. When a one-shot poll is armed, a read instead returns the number of the line that wins arbitration.

The processor side acknowledges a request with a single-cycle strobe. The unit answers with an 8-bit vector, which is the programmed vector base combined with the winning line. It also updates the in-service state and pulses a one-hot clear back to the external request latch. The latch itself sits outside the unit and feeds the pending bits in. The unit holds the mask, the in-service bits, the rotating priority base, the vector base and the mode flags. Priority resolution is done by internal resolver instances. The output request is registered. It is raised when the best unmasked pending line outranks the best line currently in service.

Top module: `intc_cmd_ack_unit`

## Requirements
- R1: After reset the mask, the in-service bits, the rotation base, the vector base, the init step and all mode flags are zero. `int_req_o`, `rdata_o`, `vec_o` and `pend_clr_o` are zero.
- R2: A command-port write with bit 4 set clears all owned state and enters init step 1. It records bit 0 as "mode word expected". A data write in step 1 stores bits 7:3 as the vector base and goes to step 2. A data write in step 2 goes to step 3 if the mode word is expected and to step 0 otherwise. A data write in step 3 takes special-nested mode from bit 4 and auto-EOI from bit 1, then goes to step 0. While the step is not 0, `int_req_o` stays low.
- R3: In step 0 a data-port write loads the mask, where bit n masks line n. A masked pending line never raises `int_req_o`. A data-port read returns the mask one cycle after the read strobe.
- R4: A command-port write with bit 4 clear and bit 3 set does three things. Bit 2 arms poll. Bit 1 loads read-select from bit 0. Bit 6 loads special-mask mode from bit 5. A command-port read returns the in-service bits when read-select is 1 and the pending bits when it is 0.
- R5: Priority order starts at the line equal to the rotation base and climbs modulo 8. `int_req_o` is high one cycle after the state allows it (step 0), when the first unmasked pending line in that order comes strictly before the first in-service line.
- R6: With bit 4 and bit 3 clear, bits 7:5 form a command. Command 1 clears the in-service bit of highest priority. Command 5 does the same and also sets the rotation base to that line + 1.
- R7: Command 3 clears the in-service bit of line bits 2:0. Command 7 does the same and also sets the base to that line + 1. Command 6 sets the base to bits 2:0 + 1. Commands 0 and 4 clear or set rotate-on-auto-EOI. Command 2 changes nothing.
- R8: An acknowledge with a valid request returns `vec_o` = {vector base, line}, sets that line's in-service bit and pulses that line's bit on `pend_clr_o`. With no valid request it returns {vector base, 3'b111} and changes no state. `pend_clr_o` is never more than one-hot.
- R9: In auto-EOI mode an acknowledge leaves the in-service bits unchanged. When rotate-on-auto-EOI is also set, it moves the base to the acknowledged line + 1.
- R10: A read while poll is armed returns the winning line number, or 7 if no line wins. It clears that line's in-service bit, pulses its `pend_clr_o` bit, and disarms poll.
- R11: In special-mask mode, in-service lines that are masked do not block lower-priority requests.
- R12: In special-nested mode, the in-service bit of the cascade line (line 2) does not block requests.
- R13: In a cycle with an acknowledge, a write or read strobe is ignored. A read without poll armed changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| port_sel | input | 1 | 0 selects the command port, 1 selects the data port |
| wdata | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid one cycle after `rd_stb` |
| pend_i | input | 8 | Pending bits from the external request latch |
| pend_clr_o | output | 8 | One-cycle one-hot clear pulse to the request latch |
| ack_stb | input | 1 | Single-cycle interrupt acknowledge strobe |
| vec_o | output | 8 | Vector, valid one cycle after `ack_stb` |
| int_req_o | output | 1 | Registered interrupt request |

## Verification
Directed sequences first cover the init paths, both with and without the mode word. They then run each command code against in-service patterns chosen so that non-specific, rotating and specific clears pick different lines. Multi-line requests under a moved rotation base show that the order follows the base and not the line number. Special mask, special nesting, auto-EOI rotation, the spurious vector and a collision between acknowledge and write each get a case where the correct result differs from what an unmodified priority scheme would give. A seeded random mix of raises, acknowledges, commands, mask writes, reads and polls is then compared, one operation at a time, with a bench model of the register state.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_BASE = 2'd1,
    STEP_SKIP = 2'd2,
    STEP_MODE = 2'd3
  } init_step_e;

  typedef struct packed {
    logic       init;
    logic       rdctl;
    logic       cmd;
    logic       data;
    logic       rd;
    logic [2:0] code;
  } bus_op_t;

endpackage

// File: rtl/intc_prio_resolve.sv
module intc_prio_resolve #(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES),
  localparam int PW = LW + 1
) (
  input  logic [N_LINES-1:0] mask,
  input  logic [LW-1:0]      base,
  output logic               found,
  output logic [PW-1:0]      prio,
  output logic [LW-1:0]      line
);

  always_comb begin
    logic [LW-1:0] idx;
    found = 1'b0;
    prio  = PW'(N_LINES);
    line  = '0;
    for (int p = N_LINES - 1; p >= 0; p--) begin
      idx = base + LW'(p);
      if (mask[idx]) begin
        found = 1'b1;
        prio  = PW'(p);
        line  = idx;
      end
    end
  end

endmodule

// File: rtl/intc_wr_decode.sv
module intc_wr_decode
  import intc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          ack_stb,
  input  logic          port_sel,
  input  logic [DW-1:0] wdata,
  output bus_op_t       op
);

  logic wr_ok;
  logic cmd_wr;

  assign wr_ok  = wr_stb && !ack_stb;
  assign cmd_wr = wr_ok && !port_sel;

  always_comb begin
    op       = '0;
    op.init  = cmd_wr && wdata[4];
    op.rdctl = cmd_wr && !wdata[4] && wdata[3];
    op.cmd   = cmd_wr && !wdata[4] && !wdata[3];
    op.data  = wr_ok && port_sel;
    op.rd    = rd_stb && !wr_stb && !ack_stb;
    op.code  = wdata[7:5];
  end

endmodule

// File: rtl/intc_cmd_ack_unit.sv
module intc_cmd_ack_unit
  import intc_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int DW        = 8,
  parameter int CASC_LINE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic               rd_stb,
  input  logic               port_sel,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata_o,
  input  logic [N_LINES-1:0] pend_i,
  output logic [N_LINES-1:0] pend_clr_o,
  input  logic               ack_stb,
  output logic [DW-1:0]      vec_o,
  output logic               int_req_o
);

  localparam int LW  = $clog2(N_LINES);
  localparam int PW  = LW + 1;
  localparam int VBW = DW - LW;
  localparam int NRES = 3;  // 0: request, 1: current level, 2: plain in-service

  logic [N_LINES-1:0] imr_q, isr_q;
  logic [LW-1:0]      base_q;
  logic [VBW-1:0]     vbase_q;
  init_step_e         step_q;
  logic               need_mode_q, rsel_q, poll_q, smm_q, snm_q, aeoi_q, rae_q;

  bus_op_t op;

  intc_wr_decode #(.DW(DW)) u_dec (
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .ack_stb (ack_stb),
    .port_sel(port_sel),
    .wdata   (wdata),
    .op      (op)
  );

  logic [N_LINES-1:0] res_mask  [NRES];
  logic               res_found [NRES];
  logic [PW-1:0]      res_prio  [NRES];
  logic [LW-1:0]      res_line  [NRES];
  logic [N_LINES-1:0] casc_bit;

  assign casc_bit = N_LINES'(1) << CASC_LINE;

  always_comb begin
    res_mask[0] = pend_i & ~imr_q;
    res_mask[1] = isr_q & ~(smm_q ? imr_q : '0) & ~(snm_q ? casc_bit : '0);
    res_mask[2] = isr_q;
  end

  for (genvar g = 0; g < NRES; g++) begin : g_res
    intc_prio_resolve #(.N_LINES(N_LINES)) u_res (
      .mask (res_mask[g]),
      .base (base_q),
      .found(res_found[g]),
      .prio (res_prio[g]),
      .line (res_line[g])
    );
  end

  logic          req_valid;
  logic [LW-1:0] req_line;
  logic [LW-1:0] wr_line;

  assign req_valid = res_found[0] && (res_prio[0] < res_prio[1]);
  assign req_line  = res_line[0];
  assign wr_line   = wdata[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q       <= '0;
      isr_q       <= '0;
      base_q      <= '0;
      vbase_q     <= '0;
      step_q      <= STEP_RUN;
      need_mode_q <= 1'b0;
      rsel_q      <= 1'b0;
      poll_q      <= 1'b0;
      smm_q       <= 1'b0;
      snm_q       <= 1'b0;
      aeoi_q      <= 1'b0;
      rae_q       <= 1'b0;
      rdata_o     <= '0;
      vec_o       <= '0;
      pend_clr_o  <= '0;
      int_req_o   <= 1'b0;
    end else begin
      pend_clr_o <= '0;
      int_req_o  <= (step_q == STEP_RUN) && !op.init && req_valid;
      if (ack_stb) begin
        if (req_valid) begin
          vec_o      <= {vbase_q, req_line};
          pend_clr_o <= N_LINES'(1) << req_line;
          if (aeoi_q) begin
            if (rae_q) base_q <= req_line + LW'(1);
          end else begin
            isr_q[req_line] <= 1'b1;
          end
        end else begin
          vec_o <= {vbase_q, {LW{1'b1}}};
        end
      end else if (op.init) begin
        imr_q       <= '0;
        isr_q       <= '0;
        base_q      <= '0;
        vbase_q     <= '0;
        rsel_q      <= 1'b0;
        poll_q      <= 1'b0;
        smm_q       <= 1'b0;
        snm_q       <= 1'b0;
        aeoi_q      <= 1'b0;
        rae_q       <= 1'b0;
        step_q      <= STEP_BASE;
        need_mode_q <= wdata[0];
      end else if (op.rdctl) begin
        if (wdata[2]) poll_q <= 1'b1;
        if (wdata[1]) rsel_q <= wdata[0];
        if (wdata[6]) smm_q  <= wdata[5];
      end else if (op.cmd) begin
        case (op.code)
          3'd0, 3'd4: rae_q <= op.code[2];
          3'd1, 3'd5: begin
            if (res_found[2]) begin
              isr_q[res_line[2]] <= 1'b0;
              if (op.code[2]) base_q <= res_line[2] + LW'(1);
            end
          end
          3'd3: isr_q[wr_line] <= 1'b0;
          3'd6: base_q <= wr_line + LW'(1);
          3'd7: begin
            isr_q[wr_line] <= 1'b0;
            base_q         <= wr_line + LW'(1);
          end
          default: ;
        endcase
      end else if (op.data) begin
        case (step_q)
          STEP_RUN:  imr_q <= wdata[N_LINES-1:0];
          STEP_BASE: begin
            vbase_q <= wdata[DW-1:LW];
            step_q  <= STEP_SKIP;
          end
          STEP_SKIP: step_q <= need_mode_q ? STEP_MODE : STEP_RUN;
          default: begin
            snm_q  <= wdata[4];
            aeoi_q <= wdata[1];
            step_q <= STEP_RUN;
          end
        endcase
      end else if (op.rd) begin
        if (poll_q) begin
          poll_q <= 1'b0;
          if (req_valid) begin
            rdata_o         <= DW'(req_line);
            isr_q[req_line] <= 1'b0;
            pend_clr_o      <= N_LINES'(1) << req_line;
          end else begin
            rdata_o <= DW'(N_LINES - 1);
          end
        end else if (port_sel) begin
          rdata_o <= DW'(imr_q);
        end else begin
          rdata_o <= DW'(rsel_q ? isr_q : pend_i);
        end
      end
    end
  end

  AST_INIT_REQ_LOW: assert property (@(posedge clk) disable iff (rst)
    (step_q != STEP_RUN) |=> !int_req_o);  // R2
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && req_valid && !aeoi_q) |=> isr_q[$past(req_line)]);  // R8
  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && !req_valid) |=> (vec_o[LW-1:0] == {LW{1'b1}}) && (pend_clr_o == '0));  // R8
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend_clr_o));  // R8
  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && aeoi_q) |=> $stable(isr_q));  // R9
  AST_POLL_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (op.rd && poll_q) |=> !poll_q);  // R10
  AST_PLAIN_READ_PURE: assert property (@(posedge clk) disable iff (rst)
    (op.rd && !poll_q) |=> ($stable(isr_q) && $stable(imr_q) && $stable(base_q)));  // R13

endmodule

// File: tb/intc_cmd_ack_unit_tb.sv
module intc_cmd_ack_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0, rd_stb = 1'b0, ack_stb = 1'b0, port_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_o, vec_o, pend_clr_o;
  logic       int_req_o;
  logic [7:0] lat_q;
  logic [7:0] set_req = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  intc_cmd_ack_unit dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .port_sel(port_sel),
    .wdata(wdata), .rdata_o(rdata_o), .pend_i(lat_q), .pend_clr_o(pend_clr_o),
    .ack_stb(ack_stb), .vec_o(vec_o), .int_req_o(int_req_o)
  );

  // external request latch owned by the bench
  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else     lat_q <= (lat_q & ~pend_clr_o) | set_req;
  end

  // bench model of the register state
  logic [7:0] m_imr = '0, m_isr = '0, m_vbase = '0;
  int         m_base = 0, m_step = 0;
  bit         m_need = 0, m_rsel = 0, m_poll = 0, m_smm = 0, m_snm = 0, m_aeoi = 0, m_rae = 0;

  function automatic int prio_of(logic [7:0] m, int b);
    for (int p = 0; p < 8; p++) if (m[(p + b) % 8]) return p;
    return 8;
  endfunction

  function automatic bit m_valid(output int ln);
    logic [7:0] cm;
    int rp;
    rp = prio_of(lat_q & ~m_imr, m_base);
    ln = (rp + m_base) % 8;
    cm = m_isr;
    if (m_smm) cm = cm & ~m_imr;
    if (m_snm) cm[2] = 1'b0;
    return (rp < 8) && (rp < prio_of(cm, m_base));
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    int ln;
    bit v;
    @(negedge clk);
    @(negedge clk);
    v = m_valid(ln);
    chk((m_step != 0) ? "R2 int_req" : "R5 int_req", int'(int_req_o), int'((m_step == 0) && v));
  endtask

  task automatic m_write(bit a, logic [7:0] d);
    int p, l;
    if (!a) begin
      if (d[4]) begin
        m_imr = 0; m_isr = 0; m_base = 0; m_vbase = 0; m_rsel = 0; m_poll = 0;
        m_smm = 0; m_snm = 0; m_aeoi = 0; m_rae = 0; m_step = 1; m_need = d[0];
      end else if (d[3]) begin
        if (d[2]) m_poll = 1;
        if (d[1]) m_rsel = d[0];
        if (d[6]) m_smm = d[5];
      end else begin
        case (d[7:5])
          3'd0, 3'd4: m_rae = d[7];
          3'd1, 3'd5: begin
            p = prio_of(m_isr, m_base);
            if (p != 8) begin
              l = (p + m_base) % 8;
              m_isr[l] = 1'b0;
              if (d[7]) m_base = (l + 1) % 8;
            end
          end
          3'd3: m_isr[d[2:0]] = 1'b0;
          3'd6: m_base = (int'(d[2:0]) + 1) % 8;
          3'd7: begin
            m_isr[d[2:0]] = 1'b0;
            m_base = (int'(d[2:0]) + 1) % 8;
          end
          default: ;
        endcase
      end
    end else begin
      case (m_step)
        0: m_imr = d;
        1: begin m_vbase = d & 8'hF8; m_step = 2; end
        2: m_step = m_need ? 3 : 0;
        default: begin m_snm = d[4]; m_aeoi = d[1]; m_step = 0; end
      endcase
    end
  endtask

  task automatic do_wr(bit a, logic [7:0] d);
    @(negedge clk);
    wr_stb = 1; port_sel = a; wdata = d;
    m_write(a, d);
    @(negedge clk);
    wr_stb = 0;
    settle();
  endtask

  task automatic do_rd(bit a, string tag, int hand = -1);
    int ln, exp;
    logic [7:0] clr;
    bit v;
    @(negedge clk);
    rd_stb = 1; port_sel = a;
    clr = 0;
    if (m_poll) begin
      v = m_valid(ln);
      if (v) begin exp = ln; m_isr[ln] = 1'b0; clr[ln] = 1'b1; end
      else exp = 7;
      m_poll = 0;
    end else if (a) exp = m_imr;
    else exp = m_rsel ? m_isr : lat_q;
    @(negedge clk);
    rd_stb = 0;
    chk(tag, rdata_o, exp);
    chk(tag, pend_clr_o, clr);
    if (hand >= 0) chk(tag, rdata_o, hand);
    settle();
  endtask

  task automatic do_ack(string tag, int hand = -1, bit with_wr = 0);
    int ln, exp;
    logic [7:0] clr;
    bit v;
    @(negedge clk);
    ack_stb = 1;
    if (with_wr) begin wr_stb = 1; port_sel = 1; wdata = 8'hFF; end
    v = m_valid(ln);
    clr = 0;
    if (v) begin
      exp = m_vbase | ln; clr[ln] = 1'b1;
      if (m_aeoi) begin if (m_rae) m_base = (ln + 1) % 8; end
      else m_isr[ln] = 1'b1;
    end else exp = m_vbase | 7;
    @(negedge clk);
    ack_stb = 0; wr_stb = 0;
    chk(tag, vec_o, exp);
    chk(tag, pend_clr_o, clr);
    if (hand >= 0) chk(tag, vec_o, hand);
    settle();
  endtask

  task automatic raise(logic [7:0] m);
    @(negedge clk);
    set_req = m;
    @(negedge clk);
    set_req = 0;
    settle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_req", int_req_o, 0);
    chk("R1 vec", vec_o, 0);
    chk("R1 rdata", rdata_o, 0);
    chk("R1 clr", pend_clr_o, 0);
    do_rd(1, "R1 mask read", 0);
    do_rd(0, "R1 pending read", 0);

    // R2 init with mode word; request held low during init
    do_wr(0, 8'h11);
    raise(8'h01);
    chk("R2 req low in init", int_req_o, 0);
    do_wr(1, 8'h40);
    do_wr(1, 8'h00);
    chk("R2 req low step3", int_req_o, 0);
    do_wr(1, 8'h00);
    chk("R5 req after init", int_req_o, 1);

    // R8 acknowledge, R4 read-select
    do_ack("R8 ack line0", 8'h40);
    do_wr(0, 8'h0B);
    do_rd(0, "R4 isr read", 8'h01);
    raise(8'h04);
    chk("R5 lower blocked", int_req_o, 0);
    do_wr(0, 8'h20);
    chk("R6 nonspecific eoi", int_req_o, 1);
    do_ack("R8 ack line2", 8'h42);
    raise(8'h02);
    chk("R5 higher preempts", int_req_o, 1);
    do_ack("R8 ack line1", 8'h41);
    do_rd(0, "R4 isr two", 8'h06);
    do_wr(0, 8'hA0);
    do_rd(0, "R6 rotating eoi", 8'h04);
    do_wr(0, 8'h62);
    do_rd(0, "R7 specific eoi", 8'h00);

    // R7 set priority, no-op, rotate specific
    do_wr(0, 8'hC4);
    raise(8'h81);
    do_ack("R7 base5 picks line7", 8'h47);
    do_wr(0, 8'h40);
    do_rd(0, "R7 cmd2 no-op", 8'h80);
    do_wr(0, 8'hE7);
    do_ack("R7 rotate specific", 8'h40);
    do_wr(0, 8'h20);

    // R8 spurious
    do_ack("R8 spurious", 8'h47);

    // R3 mask
    do_wr(1, 8'h01);
    raise(8'h01);
    chk("R3 masked line", int_req_o, 0);
    do_rd(1, "R3 mask read", 8'h01);

    // R10 poll
    do_wr(1, 8'h00);
    do_wr(0, 8'h0C);
    do_rd(0, "R10 poll read", 0);
    do_wr(0, 8'h0C);
    do_rd(0, "R10 poll none", 7);
    do_rd(0, "R10 poll disarmed");

    // R11 special mask
    raise(8'h01);
    do_ack("R11 setup", 8'h40);
    raise(8'h08);
    chk("R11 blocked", int_req_o, 0);
    do_wr(1, 8'h01);
    do_wr(0, 8'h68);
    chk("R11 special mask", int_req_o, 1);
    do_wr(0, 8'h48);
    chk("R11 off", int_req_o, 0);

    // R13 ack with write collision
    do_wr(1, 8'h00);
    do_ack("R13 ack wins", -1, 1);
    do_rd(1, "R13 mask untouched", 8'h00);

    // R9 auto-EOI with rotation
    do_wr(0, 8'h11);
    do_wr(1, 8'h20);
    do_wr(1, 8'h00);
    do_wr(1, 8'h02);
    do_wr(0, 8'h80);
    do_wr(0, 8'h0B);
    raise(8'h08);
    do_ack("R9 aeoi ack", 8'h23);
    do_rd(0, "R9 isr unchanged", 8'h00);
    raise(8'h09);
    do_ack("R9 rotated base", 8'h20);

    // R12 special nested
    do_wr(0, 8'h11);
    do_wr(1, 8'h08);
    do_wr(1, 8'h00);
    do_wr(1, 8'h10);
    raise(8'h04);
    do_ack("R12 cascade ack", 8'h0A);
    raise(8'h20);
    chk("R12 special nested", int_req_o, 1);

    // random mix against the model
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 11))
        0, 1: raise(8'($urandom_range(0, 255)));
        2, 3: do_ack("R8 random ack");
        4: do_wr(0, 8'h20);
        5: do_wr(0, 8'hA0);
        6: do_wr(0, {3'b011, 2'b00, 3'($urandom_range(0, 7))});
        7: do_wr(0, {$urandom_range(0, 1) ? 3'b110 : 3'b111, 2'b00, 3'($urandom_range(0, 7))});
        8: do_wr(1, 8'($urandom_range(0, 255)) & 8'($urandom_range(0, 255)));
        9: do_rd($urandom_range(0, 1) != 0, "R4 random read");
        10: do_wr(0, {1'b0, 2'($urandom_range(0, 3)), 2'b01, 3'($urandom_range(0, 7))});
        default: begin
          do_wr(0, 8'h0C);
          do_rd(0, "R10 random poll");
        end
      endcase
    end
    finish_run();
  end

endmodule